// File: doc/BRIEF.md
# Minimal Accumulator CPU

This block is a small 8-bit accumulator machine. One internal 8-bit bus carries both addresses and data between the parts of the machine. The parts are a 4-bit program counter, a memory address register, a 16-byte RAM that holds program and data together, an instruction register, an accumulator, a second operand register, a combinational two's-complement adder-subtractor and an output register that drives eight LEDs. Each instruction byte carries an operation in its upper four bits and a RAM address in its lower four bits.

Every instruction takes a fixed sequence of six clock cycles. The first three cycles fetch the instruction: address transfer, counter increment and instruction load. The last three cycles execute it. A state that an instruction does not need passes with no effect.

The RAM is filled through a preload port, normally while reset is held. Execution starts at address 0 when reset is released. The machine stops for good on the halt instruction, and only reset restarts it.

Top module: `acc_cpu`

## Requirements
- R1: Synchronous active-high reset clears the program counter, accumulator, operand register, output register, phase counter and halted flag. After reset `leds` is 0 and `halted` is 0, and fetching starts at address 0. RAM contents are kept.
- R2: An instruction byte holds its operation code in bits 7:4 and its operand address in bits 3:0. Code 0000 (load) copies RAM[address] into the accumulator.
- R3: Code 0001 (add) sets the accumulator to accumulator + RAM[address] modulo 256. No carry is kept.
- R4: Code 0010 (subtract) sets the accumulator to accumulator − RAM[address] modulo 256, in two's complement.
- R5: Code 1110 (output) copies the accumulator into the output register. `leds` takes the new value on the 4th rising edge of that instruction's cycle and changes at no other time.
- R6: Code 1111 (halt) sets `halted` on the 4th rising edge of its cycle. After that, `halted`, `leds` and the accumulator stay constant until reset.
- R7: Every instruction occupies exactly six rising edges, whatever its code. Instruction k after reset (k counted from 0) has its 4th edge at edge 6k+4 after reset release.
- R8: A code other than 0000, 0001, 0010, 1110 and 1111 changes no register during its three execute states.
- R9: The program counter steps by one per instruction and wraps from 15 to 0.
- R10: With `load_en` high, a rising edge writes `load_data` into RAM[`load_addr`].
- R11: At most one source drives the internal bus in any state. With no source enabled, the bus reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write enable |
| load_addr | input | 4 | Preload RAM address |
| load_data | input | 8 | Preload RAM data |
| leds | output | 8 | Output register value |
| halted | output | 1 | High after a halt instruction has executed |

## Verification
The hardest situation to reach from the ports is a program counter wrap. Sixteen full instructions must execute, with values that make the wrap visible on the LEDs. The stimulus fills the middle of RAM with undefined codes, which run as no-ops. It places an add at address 15, then repeats the add at address 0 after the wrap, so that a second output instruction shows a value that only a correct wrap produces. A behavioural reference model is stepped every clock and compared on every cycle, so the exact edge at which the LEDs and the halted flag change is checked as well.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int OP_W   = DATA_W - ADDR_W;

    localparam logic [OP_W-1:0] OP_LOAD = 4'b0000;
    localparam logic [OP_W-1:0] OP_ADD  = 4'b0001;
    localparam logic [OP_W-1:0] OP_SUB  = 4'b0010;
    localparam logic [OP_W-1:0] OP_SHOW = 4'b1110;
    localparam logic [OP_W-1:0] OP_STOP = 4'b1111;

    typedef enum logic [2:0] {
        PH_ADDR  = 3'd0,
        PH_INC   = 3'd1,
        PH_FETCH = 3'd2,
        PH_EX1   = 3'd3,
        PH_EX2   = 3'd4,
        PH_EX3   = 3'd5
    } phase_e;

    typedef struct packed {
        logic drv_pc;
        logic drv_ram;
        logic drv_ir;
        logic drv_acc;
        logic drv_alu;
        logic ld_mar;
        logic ld_ir;
        logic ld_acc;
        logic ld_b;
        logic ld_out;
        logic inc_pc;
        logic sub;
        logic set_halt;
    } ctrl_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_ADDR:  return PH_INC;
            PH_INC:   return PH_FETCH;
            PH_FETCH: return PH_EX1;
            PH_EX1:   return PH_EX2;
            PH_EX2:   return PH_EX3;
            default:  return PH_ADDR;
        endcase
    endfunction

    function automatic logic uses_memory(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/cpu_ram.sv
module cpu_ram #(
    parameter int DW = cpu_pkg::DATA_W,
    parameter int AW = cpu_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
    parameter int DW = cpu_pkg::DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y
);
    logic [DW-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        y     = a + b_eff + {{(DW-1){1'b0}}, sub};
    end
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output phase_e          phase,
    output ctrl_t           ctl,
    output logic            halted
);
    phase_e phase_q;
    logic   halted_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_ADDR;
            halted_q <= 1'b0;
        end else begin
            if (!halted_q) phase_q <= next_phase(phase_q);
            if (ctl.set_halt) halted_q <= 1'b1;
        end
    end

    always_comb begin
        ctl = '0;
        if (!halted_q) begin
            case (phase_q)
                PH_ADDR: begin
                    ctl.drv_pc = 1'b1;
                    ctl.ld_mar = 1'b1;
                end
                PH_INC: ctl.inc_pc = 1'b1;
                PH_FETCH: begin
                    ctl.drv_ram = 1'b1;
                    ctl.ld_ir   = 1'b1;
                end
                PH_EX1: begin
                    if (uses_memory(opcode)) begin
                        ctl.drv_ir = 1'b1;
                        ctl.ld_mar = 1'b1;
                    end else if (opcode == OP_SHOW) begin
                        ctl.drv_acc = 1'b1;
                        ctl.ld_out  = 1'b1;
                    end else if (opcode == OP_STOP) begin
                        ctl.set_halt = 1'b1;
                    end
                end
                PH_EX2: begin
                    if (opcode == OP_LOAD) begin
                        ctl.drv_ram = 1'b1;
                        ctl.ld_acc  = 1'b1;
                    end else if (opcode == OP_ADD || opcode == OP_SUB) begin
                        ctl.drv_ram = 1'b1;
                        ctl.ld_b    = 1'b1;
                    end
                end
                PH_EX3: begin
                    if (opcode == OP_ADD || opcode == OP_SUB) begin
                        ctl.drv_alu = 1'b1;
                        ctl.ld_acc  = 1'b1;
                        ctl.sub     = (opcode == OP_SUB);
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase  = phase_q;
    assign halted = halted_q;

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.drv_pc, ctl.drv_ram, ctl.drv_ir, ctl.drv_acc, ctl.drv_alu})); // R11

    AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EX3 && !halted_q) |=> (phase_q == PH_ADDR)); // R7

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> halted_q); // R6

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(halted_q) |-> ($past(phase_q) == PH_EX1 && $past(opcode) == OP_STOP)); // R6
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] leds,
    output logic              halted
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, acc_q, b_q, out_q;
    logic [DATA_W-1:0] bus, ram_rd, alu_y;
    phase_e            phase;
    ctrl_t             ctl;

    cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_q[DATA_W-1:ADDR_W]),
        .phase  (phase),
        .ctl    (ctl),
        .halted (halted)
    );

    cpu_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (mar_q),
        .rd_data (ram_rd)
    );

    cpu_alu #(.DW(DATA_W)) u_alu (
        .a   (acc_q),
        .b   (b_q),
        .sub (ctl.sub),
        .y   (alu_y)
    );

    always_comb begin
        bus = '0;
        if (ctl.drv_pc)  bus = bus | {{PAD_W{1'b0}}, pc_q};
        if (ctl.drv_ram) bus = bus | (ctl.drv_ram ? ram_rd : '0);
        if (ctl.drv_ir)  bus = bus | {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
        if (ctl.drv_acc) bus = bus | acc_q;
        if (ctl.drv_alu) bus = bus | alu_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            b_q   <= '0;
            out_q <= '0;
        end else begin
            if (ctl.inc_pc) pc_q  <= pc_q + 1'b1;
            if (ctl.ld_mar) mar_q <= bus[ADDR_W-1:0];
            if (ctl.ld_ir)  ir_q  <= bus;
            if (ctl.ld_acc) acc_q <= bus;
            if (ctl.ld_b)   b_q   <= bus;
            if (ctl.ld_out) out_q <= bus;
        end
    end

    assign leds = out_q;

    AST_LEDS_ONLY_EX1: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_EX1) |=> $stable(leds)); // R5

    AST_FROZEN_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(acc_q) && $stable(leds))); // R6

    AST_PC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pc_q == {ADDR_W{1'b1}} && phase == PH_INC && !halted) |=> (pc_q == '0)); // R9

    AST_UNDEF_NO_ACC: assert property (@(posedge clk) disable iff (rst)
        (phase inside {PH_EX1, PH_EX2, PH_EX3} && !uses_memory(ir_q[DATA_W-1:ADDR_W]))
        |=> $stable(acc_q)); // R8
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [7:0] leds;
    logic       halted;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] img [16];

    // behavioural reference machine
    int m_pc, m_mar, m_ir, m_acc, m_b, m_out, m_t, m_op;
    bit m_halt;

    always #5 clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .leds(leds), .halted(halted)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_mar = 0; m_ir = 0; m_acc = 0; m_b = 0;
            m_out = 0; m_t = 0; m_halt = 0;
        end else if (!m_halt) begin
            m_op = m_ir / 16;
            case (m_t)
                0: m_mar = m_pc;
                1: m_pc = (m_pc + 1) % 16;
                2: m_ir = img[m_mar];
                3: begin
                    if (m_op <= 2) m_mar = m_ir % 16;
                    else if (m_op == 14) m_out = m_acc;
                    else if (m_op == 15) m_halt = 1;
                end
                4: begin
                    if (m_op == 0) m_acc = img[m_mar];
                    else if (m_op <= 2) m_b = img[m_mar];
                end
                default: begin
                    if (m_op == 1) m_acc = (m_acc + m_b) % 256;
                    else if (m_op == 2) m_acc = (m_acc - m_b + 256) % 256;
                end
            endcase
            m_t = (m_t + 1) % 6;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 cycle model leds", leds, m_out);
            chk("R7 cycle model halted", halted, m_halt);
        end
    end

    task automatic load_and_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            load_en = 1'b1; load_addr = 4'(i); load_data = img[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        chk("R1 reset leds", leds, 0);
        chk("R1 reset halted", halted, 0);
        rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);

        // Program 1: load then output then halt (R2, R10)
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'h0D; img[1] = 8'hE0; img[2] = 8'hF0; img[13] = 8'h5A;
        load_and_reset();
        edges(9);
        chk("R5 leds before output edge", leds, 8'h00);
        edges(1);
        chk("R2 R10 load value shown", leds, 8'h5A);
        edges(5);
        chk("R6 not halted before edge 16", halted, 0);
        edges(1);
        chk("R6 halted at edge 16", halted, 1);

        // Program 2: add wrap, subtract wrap, outputs, halt (R3, R4, R5, R6)
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'h09; img[1] = 8'h1A; img[2] = 8'hE0; img[3] = 8'h2B;
        img[4] = 8'hE0; img[5] = 8'hF0;
        img[9] = 8'hF0; img[10] = 8'h20; img[11] = 8'h30;
        load_and_reset();
        edges(15);
        chk("R5 leds unchanged at edge 15", leds, 8'h00);
        edges(1);
        chk("R3 add wraps F0+20", leds, 8'h10);
        edges(6);
        chk("R5 leds held between outputs", leds, 8'h10);
        edges(6);
        chk("R4 subtract wraps 10-30", leds, 8'hE0);
        edges(5);
        chk("R6 halted low at edge 33", halted, 0);
        edges(1);
        chk("R6 halted high at edge 34", halted, 1);
        edges(30);
        chk("R6 leds frozen after halt", leds, 8'hE0);
        chk("R6 halted stays", halted, 1);

        // Program 3: undefined codes and counter wrap (R8, R9, R1 after run)
        for (int i = 0; i < 16; i++) img[i] = 8'h80;
        img[0] = 8'h1E; img[1] = 8'h73; img[2] = 8'hE0;
        img[14] = 8'h42; img[15] = 8'h1E;
        load_and_reset();
        edges(16);
        chk("R8 output after add", leds, 8'h42);
        edges(6 * 16 - 1);
        chk("R8 undefined codes leave value", leds, 8'h42);
        edges(1);
        chk("R9 wrap re-executes address 0", leds, 8'hC6);
        chk("R11 running, not halted", halted, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule